// File: doc/BRIEF.md
# Bus Phase Change Sequencer

This block owns the three information-transfer phase lines of a parallel SCSI target: message, command/data and direction. Control logic asks for a new phase by pulsing a request with a 3-bit phase code, or asks for bus-free. The sequencer waits until the initiator has released ACK, and only then touches the lines. If the requested code already sits on the lines, it drives nothing new and adds no delay. Otherwise it applies the new code and keeps `busy` high for a settle window. That window covers the data release time plus the bus settle time, about 800 ns. In legacy compatibility mode the window grows by a further 100 us, which slow early controllers need before REQ.

Downstream handshake logic treats `busy` as a gate: it asserts REQ only once `busy` is low. All delays are counted in clock cycles. They are derived from a clock-frequency parameter, with 50 MHz as the default. A synchronous reset returns the lines to code 0 and drops any wait in progress.

Top module: `pcc_phase_ctrl`

## Requirements
- R1: On any clock edge that samples `rst` high, the phase outputs become 000 and `busy` becomes 0 at that edge. Any wait or settle in progress is abandoned.
- R2: Phase code bit 2 drives `phase_msg`, bit 1 drives `phase_cd` and bit 0 drives `phase_io`.
- R3: A request with `req_free` high drives code 000, whatever `req_phase` holds.
- R4: The phase outputs never change while the synchronized ACK is asserted. If `ack_in` is first sampled low at edge Ea while a request waits, the outputs change at edge Ea+SYNC_STAGES. If ACK is already released, the outputs change on the first edge after acceptance.
- R5: In normal mode, `busy` remains high for exactly SETTLE_CYC = ceil(800 ns × f_clk) cycles after the edge that changes the phase outputs, then falls.
- R6: In legacy mode, sampled when the request is accepted, the window is SETTLE_CYC + ceil(100 us × f_clk) cycles.
- R7: A request whose code equals the present outputs changes no output. `busy` falls on the edge where the request would otherwise have applied the phase.
- R8: A `req_valid` pulse seen while `busy` is high is ignored. The phase outputs never change without an accepted request.
- R9: `busy` rises on the edge that accepts a request (`req_valid` high while `busy` is low). It stays high through the phase change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request for a phase transition |
| req_free | input | 1 | Request targets bus-free (code 000) |
| req_phase | input | 3 | Requested phase code {msg, cd, io} |
| legacy_mode | input | 1 | Extend the settle window for old initiators |
| ack_in | input | 1 | Initiator ACK line, asynchronous, active high |
| phase_msg | output | 1 | Message phase line |
| phase_cd | output | 1 | Command/data phase line |
| phase_io | output | 1 | Direction phase line |
| busy | output | 1 | Transition in progress; REQ must stay low |

## Verification
The assertions assume `ack_in` holds at least SYNC_STAGES+1 samples clear before a phase change counts as legal. They also assume requests are single-cycle pulses whose fields are stable on the accepting edge. The bench drives every input on the falling clock edge, holds ACK steady for several cycles around each toggle, and waits a few cycles after reset before the first request. This keeps the synchronizer, which resets to "ACK asserted", from hiding a request. The sweep walks every ordered pair of phase codes in normal mode and every code in legacy mode. It then targets the ACK hold, bus-free, ignored-request and mid-settle reset cases.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int PH_W    = 3;
  localparam int BIT_MSG = 2;
  localparam int BIT_CD  = 1;
  localparam int BIT_IO  = 0;

  localparam logic [PH_W-1:0] PH_FREE = '0;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_ACK = 2'd1,
    ST_SETTLE   = 2'd2
  } seq_state_t;

  // ceiling of a time span (ns) expressed in cycles of a clock given in kHz
  function automatic int ns_to_cycles(input int clk_khz, input int span_ns);
    longint prod;
    prod = longint'(clk_khz) * longint'(span_ns);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // ceiling of a time span (us) expressed in cycles of a clock given in kHz
  function automatic int us_to_cycles(input int clk_khz, input int span_us);
    longint prod;
    prod = longint'(clk_khz) * longint'(span_us);
    return int'((prod + 64'd999) / 64'd1_000);
  endfunction

endpackage

// File: rtl/pcc_ack_sync.sv
module pcc_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_async,
  output logic ack_seen
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= ack_async;
      end
    end else begin : g_multi
      // resets to "asserted": no phase move until the pin is really sampled
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], ack_async};
      end
    end
  endgenerate

  assign ack_seen = chain_q[STAGES-1];

endmodule

// File: rtl/pcc_settle_timer.sv
module pcc_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
  import pcc_pkg::*;
#(
  parameter int SHORT_CYC = 40,
  parameter int LONG_CYC  = 5040,
  parameter int CNT_W     = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_free,
  input  logic [PH_W-1:0]  req_code,
  input  logic             legacy_mode,
  input  logic             ack_seen,
  input  logic             timer_expired,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic [PH_W-1:0]  phase_q,
  output logic             busy_q
);

  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYC - 1);

  seq_state_t      st_q, st_n;
  logic [PH_W-1:0] tgt_q, tgt_n;
  logic [PH_W-1:0] ph_n;
  logic            leg_q, leg_n;

  always_comb begin
    st_n       = st_q;
    tgt_n      = tgt_q;
    leg_n      = leg_q;
    ph_n       = phase_q;
    timer_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          tgt_n = req_free ? PH_FREE : req_code;
          leg_n = legacy_mode;
          st_n  = ST_WAIT_ACK;
        end
      end
      ST_WAIT_ACK: begin
        if (!ack_seen) begin
          if (tgt_q != phase_q) begin
            ph_n       = tgt_q;
            timer_load = 1'b1;
            st_n       = ST_SETTLE;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_SETTLE: begin
        if (timer_expired) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign timer_val = leg_q ? LONG_LOAD : SHORT_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tgt_q   <= PH_FREE;
      leg_q   <= 1'b0;
      phase_q <= PH_FREE;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      tgt_q   <= tgt_n;
      leg_q   <= leg_n;
      phase_q <= ph_n;
      busy_q  <= (st_n != ST_IDLE);
    end
  end

endmodule

// File: rtl/pcc_phase_ctrl.sv
module pcc_phase_ctrl
  import pcc_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SETTLE_NS   = 800,
  parameter int LEGACY_US   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_free,
  input  logic [2:0] req_phase,
  input  logic       legacy_mode,
  input  logic       ack_in,
  output logic       phase_msg,
  output logic       phase_cd,
  output logic       phase_io,
  output logic       busy
);

  localparam int CLK_KHZ    = CLK_HZ / 1000;
  localparam int SETTLE_CYC = (ns_to_cycles(CLK_KHZ, SETTLE_NS) < 1) ? 1
                              : ns_to_cycles(CLK_KHZ, SETTLE_NS);
  localparam int EXTRA_CYC  = us_to_cycles(CLK_KHZ, LEGACY_US);
  localparam int LONG_CYC   = SETTLE_CYC + EXTRA_CYC;
  localparam int CNT_W      = $clog2(LONG_CYC + 1);

  logic             ack_seen;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic [PH_W-1:0]  phase_q;
  logic             busy_q;

  pcc_ack_sync #(
    .STAGES(SYNC_STAGES)
  ) u_ack_sync (
    .clk      (clk),
    .rst      (rst),
    .ack_async(ack_in),
    .ack_seen (ack_seen)
  );

  pcc_settle_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  pcc_seq #(
    .SHORT_CYC(SETTLE_CYC),
    .LONG_CYC (LONG_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_free     (req_free),
    .req_code     (req_phase),
    .legacy_mode  (legacy_mode),
    .ack_seen     (ack_seen),
    .timer_expired(tmr_expired),
    .timer_load   (tmr_load),
    .timer_val    (tmr_val),
    .phase_q      (phase_q),
    .busy_q       (busy_q)
  );

  assign phase_msg = phase_q[BIT_MSG];
  assign phase_cd  = phase_q[BIT_CD];
  assign phase_io  = phase_q[BIT_IO];
  assign busy      = busy_q;

endmodule

// File: rtl/pcc_phase_ctrl_chk.sv
module pcc_phase_ctrl_chk #(
  parameter int SETTLE_CYC  = 40,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic ack_in,
  input logic phase_msg,
  input logic phase_cd,
  input logic phase_io,
  input logic busy
);

  logic [2:0]  ph;
  logic [2:0]  ph_d;
  logic [15:0] since_chg;

  assign ph = {phase_msg, phase_cd, phase_io};

  // cycles spent busy since the outputs last moved; 0 when no move is pending
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_d      <= '0;
      since_chg <= '0;
    end else begin
      ph_d <= ph;
      if (ph != ph_d)                          since_chg <= 16'd1;
      else if (!busy)                          since_chg <= '0;
      else if (since_chg != '0 && since_chg != 16'hFFFF)
                                               since_chg <= since_chg + 16'd1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ph == 3'b000 && !busy));  // R1

  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ph) && !$past(rst)) |-> !$past(ack_in, SYNC_STAGES + 1));  // R4

  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && since_chg != '0) |-> (since_chg >= 16'(SETTLE_CYC)));  // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid) |=> $stable(ph));  // R8

  AST_BUSY_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ph) && !$past(rst)) |-> busy);  // R9

endmodule

bind pcc_phase_ctrl pcc_phase_ctrl_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .ack_in   (ack_in),
  .phase_msg(phase_msg),
  .phase_cd (phase_cd),
  .phase_io (phase_io),
  .busy     (busy)
);

// File: tb/pcc_phase_ctrl_test.sv
`timescale 1ns/1ps
module pcc_phase_ctrl_test;

  localparam int CLK_HZ  = 10_000_000;
  localparam int SYNC    = 2;
  localparam int KHZ     = CLK_HZ / 1000;
  // ceil(800 ns) and ceil(100 us) in cycles of the configured clock
  localparam int T_NORM  = (KHZ * 800 + 999_999) / 1_000_000;
  localparam int T_LEG   = T_NORM + (KHZ * 100 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_free = 1'b0;
  logic [2:0] req_phase = 3'b000;
  logic       legacy_mode = 1'b0;
  logic       ack_in = 1'b0;
  logic       phase_msg, phase_cd, phase_io, busy;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic [2:0] cur = 3'b000;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  pcc_phase_ctrl #(
    .CLK_HZ     (CLK_HZ),
    .SETTLE_NS  (800),
    .LEGACY_US  (100),
    .SYNC_STAGES(SYNC)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_free   (req_free),
    .req_phase  (req_phase),
    .legacy_mode(legacy_mode),
    .ack_in     (ack_in),
    .phase_msg  (phase_msg),
    .phase_cd   (phase_cd),
    .phase_io   (phase_io),
    .busy       (busy)
  );

  function automatic logic [2:0] ph_now();
    return {phase_msg, phase_cd, phase_io};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one complete transition with ACK released; cur tracks the expected lines
  task automatic txn(input logic [2:0] code, input logic free, input logic leg);
    logic [2:0] exp;
    int         win;
    exp = free ? 3'b000 : code;
    win = leg ? T_LEG : T_NORM;
    @(negedge clk);
    req_valid = 1'b1; req_phase = code; req_free = free; legacy_mode = leg;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R9 busy on accept", int'(busy), 1);
    check(ph_now() === cur, "R4 no change before apply edge", int'(ph_now()), int'(cur));
    @(posedge clk);
    @(negedge clk);
    check(ph_now() === exp, free ? "R3 bus-free code" : "R2 phase code map",
          int'(ph_now()), int'(exp));
    if (exp == cur) begin
      check(busy === 1'b0, "R7 same phase no delay", int'(busy), 0);
    end else begin
      repeat (win - 1) @(posedge clk);
      @(negedge clk);
      check(busy === 1'b1, leg ? "R6 legacy window end-1" : "R5 settle window end-1",
            int'(busy), 1);
      @(posedge clk);
      @(negedge clk);
      check(busy === 1'b0, leg ? "R6 legacy window end" : "R5 settle window end",
            int'(busy), 0);
    end
    cur = exp;
  endtask

  initial begin : watchdog
    #(200_000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] hold_ph;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ph_now() === 3'b000, "R1 reset phase", int'(ph_now()), 0);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    rst = 1'b0;
    repeat (4) @(posedge clk);

    // normal mode: every ordered pair of codes
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        txn(3'(a), 1'b0, 1'b0);
        txn(3'(b), 1'b0, 1'b0);
      end
    end

    // legacy mode: every code, including a repeat of the present one
    for (int b = 7; b >= 0; b--) txn(3'(b), 1'b0, 1'b1);
    txn(cur, 1'b0, 1'b1);

    // bus-free with a non-zero code on req_phase
    txn(3'b110, 1'b0, 1'b0);
    txn(3'b101, 1'b1, 1'b0);

    // ACK held: no change until released, then SYNC edges later
    txn(3'b011, 1'b0, 1'b0);
    @(negedge clk); ack_in = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_phase = 3'b100; req_free = 1'b0; legacy_mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    hold_ph = 3'b011;
    begin
      bit moved = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (ph_now() !== hold_ph || busy !== 1'b1) moved = 1'b1;
      end
      check(!moved, "R4 hold while ACK asserted", int'(ph_now()), int'(hold_ph));
    end
    ack_in = 1'b0;               // first sampled low at the next edge Ea
    @(posedge clk);              // Ea
    @(posedge clk);              // Ea+1
    @(negedge clk);
    check(ph_now() === hold_ph, "R4 not before Ea+SYNC", int'(ph_now()), int'(hold_ph));
    @(posedge clk);              // Ea+2
    @(negedge clk);
    check(ph_now() === 3'b100, "R4 applied at Ea+SYNC", int'(ph_now()), 4);
    repeat (T_NORM - 1) @(posedge clk);
    @(negedge clk);
    check(busy === 1'b1, "R5 window after ACK wait", int'(busy), 1);
    @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0, "R5 window end after ACK wait", int'(busy), 0);
    cur = 3'b100;

    // request during settle is ignored
    @(negedge clk);
    req_valid = 1'b1; req_phase = 3'b010; req_free = 1'b0; legacy_mode = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(ph_now() === 3'b010, "R2 applied before ignore test", int'(ph_now()), 2);
    req_valid = 1'b1; req_phase = 3'b111;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (T_NORM + 4) @(negedge clk);
    check(ph_now() === 3'b010, "R8 busy request ignored", int'(ph_now()), 2);
    check(busy === 1'b0, "R8 no second transition", int'(busy), 0);
    cur = 3'b010;

    // reset in the middle of a legacy settle
    @(negedge clk);
    req_valid = 1'b1; req_phase = 3'b001; legacy_mode = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(busy === 1'b1, "R6 settling before reset", int'(busy), 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(ph_now() === 3'b000, "R1 mid-settle reset phase", int'(ph_now()), 0);
    check(busy === 1'b0, "R1 mid-settle reset busy", int'(busy), 0);
    rst = 1'b0;
    cur = 3'b000;
    repeat (4) @(posedge clk);
    txn(3'b111, 1'b0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule